// File: doc/BRIEF.md
# Dual-Format Serial Audio Port

This block is a serial audio port for a stereo-plus-auxiliary audio path. Each frame holds 32 bit-clock periods, split into a left word and a right word of 16 bits each. The frame rate is 32 kHz. Two serial input lines each carry a left/right pair, so every frame delivers four received channels in parallel form. One serial output line sends the left/right pair that is presented on the transmit inputs.

The port runs as master or as slave. As master it makes the bit clock and the word strobe from a system-clock enable that pulses at twice the bit rate. As slave it takes both lines from outside, passes them through two-stage synchronisers and detects their edges in the system clock domain. A format input selects where the strobe moves. It either moves exactly at the word boundary, or it moves one bit clock before it. A one-cycle frame-valid pulse tells the surrounding logic that a complete set of received words is available and that the transmit words for the next frame have been taken.

Top module: `i2s_dual_port`

## Requirements
- R1: While reset is held and in the first cycle after it, `sck_out`, `ws_out`, `sd_out`, `frame_valid` and all four received words are zero.
- R2: In master mode, `sck_out` toggles once for each cycle in which `bit_en` is high, and holds its value otherwise. One frame spans 32 bit-clock periods.
- R3: In master mode with `early_ws`=0, the first falling edge of `sck_out` after reset starts left bit 0. `ws_out` changes only on falling edges of `sck_out`. It is 0 during the 16 left bits and 1 during the 16 right bits.
- R4: In master mode with `early_ws`=1, `ws_out` moves one bit clock earlier than in R3. It is high for bit indices 15..30 of the frame and low for bit 31 and bits 0..14.
- R5: Input data is sampled on rising bit-clock edges, MSB first. A word received while the word's channel is 0 is stored in the left output of its lane, and a word received while the channel is 1 is stored in the right output. Lane A feeds `rx_a_*` and lane B feeds `rx_b_*`.
- R6: `frame_valid` is high for exactly one system clock after the last right-channel bit is captured, which is once per frame.
- R7: `sd_out` changes only on falling bit-clock edges. It sends `tx_left` in the left slot and `tx_right` in the right slot, MSB first. Both words are sampled when each word starts.
- R8: With `slave_mode`=1, the bit clock and the strobe come from `sck_in` and `ws_in`, `bit_en` has no effect, and `sck_out` and `ws_out` stay 0.
- R9: In slave mode the port receives and transmits correctly in both strobe formats.
- R10: After reset, a word is captured only if the port has seen the strobe change at the word's start. The word in progress at start-up is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_mode | input | 1 | 1: bit clock and strobe are inputs |
| early_ws | input | 1 | 1: strobe moves one bit before the word boundary |
| bit_en | input | 1 | Master clock enable, twice the bit rate |
| sck_in | input | 1 | External bit clock (slave) |
| ws_in | input | 1 | External word strobe (slave) |
| sd_in_a | input | 1 | Serial input lane A |
| sd_in_b | input | 1 | Serial input lane B |
| tx_left | input | 16 | Left word to transmit |
| tx_right | input | 16 | Right word to transmit |
| sck_out | output | 1 | Generated bit clock (master) |
| ws_out | output | 1 | Generated word strobe (master) |
| sd_out | output | 1 | Serial output data |
| rx_a_left | output | 16 | Lane A left word |
| rx_a_right | output | 16 | Lane A right word |
| rx_b_left | output | 16 | Lane B left word |
| rx_b_right | output | 16 | Lane B right word |
| frame_valid | output | 1 | One-cycle pulse per complete frame |

## Verification
The hardest case to reach is the word in progress at start-up. The receiver has not yet seen the strobe change, so that word must be thrown away, and only later words may be captured. The bench reaches this case by starting each slave run with the strobe idling high and sending frames that begin with a left word. It checks after the first frame that the left outputs are still zero while the right outputs already hold data. The early format moves the strobe edge to the other side of a rising bit clock, and so moves where the first word lock happens. Each scenario therefore runs in both formats, as master and as slave, with data that differs from frame to frame.

// File: rtl/i2s_dual_port.sv
module i2s_dual_port #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         slave_mode,
  input  logic         early_ws,
  input  logic         bit_en,
  input  logic         sck_in,
  input  logic         ws_in,
  input  logic         sd_in_a,
  input  logic         sd_in_b,
  input  logic [W-1:0] tx_left,
  input  logic [W-1:0] tx_right,
  output logic         sck_out,
  output logic         ws_out,
  output logic         sd_out,
  output logic [W-1:0] rx_a_left,
  output logic [W-1:0] rx_a_right,
  output logic [W-1:0] rx_b_left,
  output logic [W-1:0] rx_b_right,
  output logic         frame_valid
);
  localparam int FW = 2 * W;
  localparam int CW = $clog2(FW);
  localparam int PW = $clog2(W + 1);

  logic [2:0]    sck_s;
  logic [1:0]    ws_s, a_s, b_s;
  logic          sck_q, ws_q;
  logic [CW-1:0] cnt, cnt_p1, cnt_p2;
  logic          rise_ev, fall_ev, ws_at, ch;
  logic          ws_last, ch_last, word_start, last_bit;
  logic [PW-1:0] pos, pos_nxt;
  logic [W-1:0]  sha, shb, sha_nxt, shb_nxt, tsh;
  logic          load_pend, load_right;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_s <= '0;
      ws_s  <= '0;
      a_s   <= '0;
      b_s   <= '0;
    end else begin
      sck_s <= {sck_s[1:0], sck_in};
      ws_s  <= {ws_s[0], ws_in};
      a_s   <= {a_s[0], sd_in_a};
      b_s   <= {b_s[0], sd_in_b};
    end
  end

  assign cnt_p1 = CW'(cnt + CW'(1));
  assign cnt_p2 = CW'(cnt + CW'(2));

  always_ff @(posedge clk) begin
    if (!rst_n || slave_mode) begin
      sck_q <= 1'b0;
      ws_q  <= 1'b0;
      cnt   <= '1;
    end else if (bit_en) begin
      sck_q <= ~sck_q;
      if (sck_q) begin
        cnt  <= cnt_p1;
        ws_q <= early_ws ? cnt_p2[CW-1] : cnt_p1[CW-1];
      end
    end
  end

  assign sck_out = sck_q;
  assign ws_out  = ws_q;

  assign rise_ev = slave_mode ? (sck_s[1] & ~sck_s[2]) : (bit_en & ~sck_q);
  assign fall_ev = slave_mode ? (~sck_s[1] & sck_s[2]) : (bit_en & sck_q);
  assign ws_at   = slave_mode ? ws_s[1] : ws_q;
  assign ch      = early_ws ? ws_last : ws_at;

  assign word_start = (ch != ch_last);
  assign pos_nxt    = word_start ? '0 : ((pos == PW'(W)) ? pos : PW'(pos + PW'(1)));
  assign last_bit   = (pos_nxt == PW'(W - 1));
  assign sha_nxt    = {sha[W-2:0], a_s[1]};
  assign shb_nxt    = {shb[W-2:0], b_s[1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ws_last     <= 1'b0;
      ch_last     <= 1'b0;
      pos         <= PW'(W);
      sha         <= '0;
      shb         <= '0;
      tsh         <= '0;
      load_pend   <= 1'b0;
      load_right  <= 1'b0;
      rx_a_left   <= '0;
      rx_a_right  <= '0;
      rx_b_left   <= '0;
      rx_b_right  <= '0;
      frame_valid <= 1'b0;
    end else begin
      frame_valid <= 1'b0;
      if (rise_ev) begin
        ws_last    <= ws_at;
        ch_last    <= ch;
        pos        <= pos_nxt;
        sha        <= sha_nxt;
        shb        <= shb_nxt;
        load_pend  <= last_bit;
        load_right <= ~ch;
        if (last_bit) begin
          if (ch) begin
            rx_a_right  <= sha_nxt;
            rx_b_right  <= shb_nxt;
            frame_valid <= 1'b1;
          end else begin
            rx_a_left <= sha_nxt;
            rx_b_left <= shb_nxt;
          end
        end
      end else if (fall_ev) begin
        if (load_pend) begin
          tsh       <= load_right ? tx_right : tx_left;
          load_pend <= 1'b0;
        end else begin
          tsh <= {tsh[W-2:0], 1'b0};
        end
      end
    end
  end

  assign sd_out = tsh[W-1];
endmodule

// File: rtl/i2s_dual_port_chk.sv
module i2s_dual_port_chk (
  input logic clk,
  input logic rst_n,
  input logic slave_mode,
  input logic bit_en,
  input logic sck_out,
  input logic ws_out,
  input logic sd_out,
  input logic frame_valid
);
  a_r6_fv_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  a_r2_sck_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && bit_en) |=> (sck_out != $past(sck_out)));

  a_r2_sck_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && !bit_en) |=> $stable(sck_out));

  a_r8_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |=> (!sck_out && !ws_out));

  a_r3_ws_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && !$past(slave_mode) && (ws_out != $past(ws_out)))
      |-> ($past(sck_out) && !sck_out));

  a_r7_sd_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && !$past(slave_mode) && (sd_out != $past(sd_out)))
      |-> ($past(sck_out) && !sck_out));
endmodule

bind i2s_dual_port i2s_dual_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .bit_en(bit_en),
  .sck_out(sck_out), .ws_out(ws_out), .sd_out(sd_out), .frame_valid(frame_valid)
);

// File: tb/i2s_dual_port_bench.sv
module i2s_dual_port_bench;
  localparam int H = 6;
  logic clk = 1'b0;
  logic rst_n, slave_mode, early_ws, bit_en, sck_in, ws_in, sd_in_a, sd_in_b;
  logic [15:0] tx_left, tx_right;
  logic sck_out, ws_out, sd_out, frame_valid;
  logic [15:0] rx_a_left, rx_a_right, rx_b_left, rx_b_right;
  int checks = 0, errors = 0;
  int fv_cnt = 0, fv_wide = 0;
  logic fv_prev = 1'b0;
  logic ben_run = 1'b0;

  always #2 clk = ~clk;

  i2s_dual_port u_i2s_dual_port (.*);

  initial begin
    int div = 0;
    bit_en = 1'b0;
    forever begin
      @(negedge clk);
      div = (div + 1) % 4;
      bit_en = ben_run && (div == 0);
    end
  end

  initial forever begin
    @(negedge clk);
    if (frame_valid) fv_cnt++;
    if (frame_valid && fv_prev) fv_wide++;
    fv_prev = frame_valid;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] word(input int f, input int k);
    return 16'(16'h1357 * (f + 1) + 16'h2A4B * k + 16'h0811 * f * k + 16'h8001);
  endfunction

  task automatic do_reset(input logic slv, input logic early);
    @(negedge clk);
    rst_n = 1'b0; ben_run = 1'b0; slave_mode = slv; early_ws = early;
    sck_in = 1'b0; ws_in = 1'b1; sd_in_a = 1'b0; sd_in_b = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    fv_cnt = 0; fv_wide = 0;
  endtask

  task automatic t_reset;
    do_reset(1'b0, 1'b0);
    check({sck_out, ws_out, sd_out, frame_valid} == 4'b0, "R1 lines", {sck_out, ws_out, sd_out, frame_valid}, 0);
    check({rx_a_left, rx_a_right} == 32'h0, "R1 lane A", {rx_a_left, rx_a_right}, 0);
    check({rx_b_left, rx_b_right} == 32'h0, "R1 lane B", {rx_b_left, rx_b_right}, 0);
  endtask

  task automatic t_master(input logic early);
    int wsbad = 0;
    logic [31:0] cap = '0;
    do_reset(1'b0, early);
    tx_left = 16'hC3A5 ^ {15'h0, early}; tx_right = 16'h5E17;
    ben_run = 1'b1;
    for (int f = 0; f < 3; f++) begin
      for (int idx = 0; idx < 32; idx++) begin
        logic [15:0] wa, wb;
        logic expws;
        @(negedge sck_out); #1;
        wa = word(f, idx < 16 ? 0 : 1);
        wb = word(f, idx < 16 ? 2 : 3);
        sd_in_a = wa[15 - (idx % 16)];
        sd_in_b = wb[15 - (idx % 16)];
        @(posedge sck_out); #1;
        expws = early ? (((idx + 1) % 32) >= 16) : (idx >= 16);
        if (ws_out !== expws) wsbad++;
        if (f == 2) cap = {cap[30:0], sd_out};
      end
    end
    repeat (10) @(negedge clk);
    ben_run = 1'b0;
    if (early) check(wsbad == 0, "R4 master early strobe", wsbad, 0);
    else       check(wsbad == 0, "R3 master strobe at boundary", wsbad, 0);
    check({rx_a_left, rx_a_right} == {word(2, 0), word(2, 1)}, "R5 lane A", {rx_a_left, rx_a_right}, {word(2, 0), word(2, 1)});
    check({rx_b_left, rx_b_right} == {word(2, 2), word(2, 3)}, "R5 lane B", {rx_b_left, rx_b_right}, {word(2, 2), word(2, 3)});
    check(cap == {tx_left, tx_right}, "R7 master transmit", cap, {tx_left, tx_right});
    check(fv_cnt == 3 && fv_wide == 0, "R6 frame_valid pulses", {fv_cnt[15:0], fv_wide[15:0]}, 32'h00030000);
  endtask

  task automatic t_slave(input logic early);
    int quietbad = 0;
    logic [31:0] cap = '0;
    do_reset(1'b1, early);
    tx_left = 16'h9B2D; tx_right = 16'h4170 ^ {15'h0, early};
    ben_run = 1'b1;
    for (int f = 0; f < 3; f++) begin
      for (int idx = 0; idx < 32; idx++) begin
        logic [15:0] wa, wb;
        wa = word(f + 4, idx < 16 ? 0 : 1);
        wb = word(f + 4, idx < 16 ? 2 : 3);
        ws_in = early ? (((idx + 1) % 32) >= 16) : (idx >= 16);
        sd_in_a = wa[15 - (idx % 16)];
        sd_in_b = wb[15 - (idx % 16)];
        repeat (H) @(negedge clk);
        sck_in = 1'b1;
        if (f == 2) cap = {cap[30:0], sd_out};
        if (sck_out || ws_out) quietbad++;
        repeat (H) @(negedge clk);
        sck_in = 1'b0;
      end
      if (f == 0) begin
        repeat (H) @(negedge clk);
        check(rx_a_left == 16'h0 && rx_a_right == word(4, 1), "R10 start-up word discarded",
              {rx_a_left, rx_a_right}, {16'h0, word(4, 1)});
      end
    end
    repeat (10) @(negedge clk);
    ben_run = 1'b0;
    check(quietbad == 0, "R8 master lines quiet in slave", quietbad, 0);
    check({rx_a_left, rx_a_right} == {word(6, 0), word(6, 1)}, "R9 slave lane A", {rx_a_left, rx_a_right}, {word(6, 0), word(6, 1)});
    check({rx_b_left, rx_b_right} == {word(6, 2), word(6, 3)}, "R9 slave lane B", {rx_b_left, rx_b_right}, {word(6, 2), word(6, 3)});
    check(cap == {tx_left, tx_right}, "R8 slave transmit", cap, {tx_left, tx_right});
    check(fv_cnt == 3 && fv_wide == 0, "R6 slave frame_valid", {fv_cnt[15:0], fv_wide[15:0]}, 32'h00030000);
  endtask

  initial begin
    rst_n = 1'b0; slave_mode = 1'b0; early_ws = 1'b0; sck_in = 1'b0; ws_in = 1'b1;
    sd_in_a = 1'b0; sd_in_b = 1'b0; tx_left = '0; tx_right = '0;
    t_reset();
    t_master(1'b0);
    t_master(1'b1);
    t_slave(1'b0);
    t_slave(1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule